// File: doc/BRIEF.md
# Bus Controller Descriptor Stack Sequencer

This block is the memory-side engine of a serial avionics bus controller. The host places a list of message descriptors in shared 16-bit RAM, along with a stack pointer and a message count for each of two descriptor areas. It then writes the start register. The sequencer handles one message per descriptor. It reads the message block address from the descriptor and fetches the control word at that address. It then hands the transfer to an abstract bus-transfer port and waits for the port to report done, with or without an error. Once the transfer has finished, it writes a block status word and a time tag back into the descriptor, advances the pointer and counts the message off.

The message count is held in complemented form. A list of N messages is loaded as the ones' complement of N, each finished message adds one to the stored word, and the list is over when the stored word reads all-ones. The host may change the area selection at any time, but the new selection is only picked up between messages. An optional stop-on-error mode halts the walk after the failing message has been written back. Two maskable interrupt pulses report the end of the list and transfer errors.

Top module: `bcs_seq`

## Requirements
- R1: After reset the block makes no RAM request, raises no transfer request and no interrupt, and stays quiet until the start register is written.
- R2: A host write with select code 2 starts the walk. The first RAM access reads the pointer word of the selected area, at 0x0100 for area A or 0x0104 for area B. The message count is read from the word above the pointer (0x0101 or 0x0105).
- R3: A descriptor is four words at the pointer address: status word at +0, time tag at +1, a spare word at +2 that is never written, and the message block address at +3.
- R4: The control word is read from the message block address before the transfer request is raised. It is presented on the transfer port together with a data address one above the message block address.
- R5: After the transfer completes, the status word written back has bit 15 set and bit 0 equal to the error flag reported with done. The time tag written is the time-tag input as sampled on the cycle where done is high.
- R6: Each finished message adds 4 to the stored pointer and 1 to the stored count. The walk ends, without a transfer, when the count read is 0xFFFF. A count of 0xFFFD therefore gives two messages and 0xFFFF gives none.
- R7: Configuration bit 13 selects the area (0 = A, 1 = B). A change takes effect only at the start of the walk or between messages, never during a message.
- R8: With configuration bit 14 set, a transfer error halts the walk once that message has been fully written back. Later descriptors are left untouched.
- R9: The interrupt mask register (select code 1) enables the end-of-list pulse with bit 0 and the error pulse with bit 1. Each pulse lasts exactly one cycle. The end-of-list pulse follows a count of 0xFFFF, and the error pulse follows each message whose transfer reported an error.
- R10: A RAM request holds its address, direction and write data until granted. Read data is taken on the cycle after the grant.
- R11: The transfer request stays high until done. No RAM access overlaps it, and a start written while the walk runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostWrSel | input | 2 | Register select: 0 config, 1 interrupt mask, 2 start, 3 none |
| hostWrData | input | 16 | Host write data |
| ramReq | output | 1 | RAM access request |
| ramWe | output | 1 | RAM write (1) or read (0) |
| ramAddr | output | 16 | RAM word address |
| ramWdata | output | 16 | RAM write data |
| ramGnt | input | 1 | RAM grant for the current request |
| ramRdata | input | 16 | RAM read data, valid the cycle after a read grant |
| xferReq | output | 1 | Bus transfer request |
| xferCtrl | output | 16 | Control word of the message |
| xferBlkAddr | output | 16 | Address of the first data word of the message |
| xferDone | input | 1 | Transfer finished (one-cycle pulse) |
| xferErr | input | 1 | Transfer error, qualified by xferDone |
| timeTag | input | 16 | Free-running time-tag value |
| irqEol | output | 1 | End-of-list interrupt pulse |
| irqErr | output | 1 | Transfer error interrupt pulse |

## Verification
Read data reaches the sequencer one cycle after its grant, and each interrupt pulse appears one cycle after the state that decides it. The RAM model in the bench therefore returns data on the edge after the grant. Interrupt pulses are counted at falling edges, where a one-cycle pulse is seen exactly once. The bench records the time tag at the falling edge where it raises done, and that value holds through the next rising edge, when the sequencer captures it. RAM words, pointers and counts are compared only after the request lines have been quiet for twenty cycles, so every write-back has landed.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // host register select codes
  typedef enum logic [1:0] {
    HS_CFG   = 2'd0,
    HS_MASK  = 2'd1,
    HS_START = 2'd2,
    HS_NONE  = 2'd3
  } hostSel_e;

  // RAM address source chosen by the control FSM
  typedef enum logic [2:0] {
    AS_PTR = 3'd0,
    AS_CNT = 3'd1,
    AS_MBA = 3'd2,
    AS_CW  = 3'd3,
    AS_BSW = 3'd4,
    AS_TT  = 3'd5
  } addrSel_e;

  localparam int CFG_AREA_BIT = 13;
  localparam int CFG_STOP_BIT = 14;
  localparam int MASK_EOL_BIT = 0;
  localparam int MASK_ERR_BIT = 1;
  localparam int BSW_DONE_BIT = 15;
  localparam int BSW_ERR_BIT  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic     ramReq;
    logic     ramWe;
    addrSel_e addrSel;
    logic     capSp;
    logic     capCnt;
    logic     capMba;
    logic     capCw;
    logic     capDone;
    logic     latchArea;
    logic     raiseEol;
    logic     raiseErr;
    logic     xferReq;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic startReq;
    logic cntAllOnes;
    logic lastErr;
    logic stopOnErr;
  } dpStatus_t;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   stat,
  input  logic        ramGnt,
  input  logic        xferDone,
  output ctrlStrobe_t strb
);

  typedef enum logic [4:0] {
    S_IDLE, S_RD_SP, S_CAP_SP, S_RD_CNT, S_CAP_CNT, S_CHK,
    S_RD_MBA, S_CAP_MBA, S_RD_CW, S_CAP_CW, S_XFER,
    S_WR_BSW, S_WR_TT, S_WR_SP, S_WR_CNT, S_NEXT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (stat.startReq) begin
          strb.latchArea = 1'b1;
          nextState      = S_RD_SP;
        end
      end
      S_RD_SP: begin
        strb.ramReq  = 1'b1;
        strb.addrSel = AS_PTR;
        if (ramGnt) nextState = S_CAP_SP;
      end
      S_CAP_SP: begin
        strb.capSp = 1'b1;
        nextState  = S_RD_CNT;
      end
      S_RD_CNT: begin
        strb.ramReq  = 1'b1;
        strb.addrSel = AS_CNT;
        if (ramGnt) nextState = S_CAP_CNT;
      end
      S_CAP_CNT: begin
        strb.capCnt = 1'b1;
        nextState   = S_CHK;
      end
      S_CHK: begin
        if (stat.cntAllOnes) begin
          strb.raiseEol = 1'b1;
          nextState     = S_IDLE;
        end else begin
          nextState = S_RD_MBA;
        end
      end
      S_RD_MBA: begin
        strb.ramReq  = 1'b1;
        strb.addrSel = AS_MBA;
        if (ramGnt) nextState = S_CAP_MBA;
      end
      S_CAP_MBA: begin
        strb.capMba = 1'b1;
        nextState   = S_RD_CW;
      end
      S_RD_CW: begin
        strb.ramReq  = 1'b1;
        strb.addrSel = AS_CW;
        if (ramGnt) nextState = S_CAP_CW;
      end
      S_CAP_CW: begin
        strb.capCw = 1'b1;
        nextState  = S_XFER;
      end
      S_XFER: begin
        strb.xferReq = 1'b1;
        if (xferDone) begin
          strb.capDone = 1'b1;
          nextState    = S_WR_BSW;
        end
      end
      S_WR_BSW: begin
        strb.ramReq  = 1'b1;
        strb.ramWe   = 1'b1;
        strb.addrSel = AS_BSW;
        if (ramGnt) nextState = S_WR_TT;
      end
      S_WR_TT: begin
        strb.ramReq  = 1'b1;
        strb.ramWe   = 1'b1;
        strb.addrSel = AS_TT;
        if (ramGnt) nextState = S_WR_SP;
      end
      S_WR_SP: begin
        strb.ramReq  = 1'b1;
        strb.ramWe   = 1'b1;
        strb.addrSel = AS_PTR;
        if (ramGnt) nextState = S_WR_CNT;
      end
      S_WR_CNT: begin
        strb.ramReq  = 1'b1;
        strb.ramWe   = 1'b1;
        strb.addrSel = AS_CNT;
        if (ramGnt) nextState = S_NEXT;
      end
      S_NEXT: begin
        strb.raiseErr = stat.lastErr;
        if (stat.lastErr && stat.stopOnErr) begin
          nextState = S_IDLE;
        end else begin
          strb.latchArea = 1'b1;
          nextState      = S_RD_SP;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R10
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ramReq && !ramGnt |=> strb.ramReq && $stable(strb.ramWe) && $stable(strb.addrSel));

  // R11
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferReq && !xferDone |=> strb.xferReq);

  // R11
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferReq |-> !strb.ramReq);

  // R8
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_NEXT && stat.lastErr && stat.stopOnErr |=> !strb.ramReq && !strb.xferReq);

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int             DW         = 16,
  parameter int             AW         = 16,
  parameter logic [AW-1:0]  PTR_A      = 16'h0100,
  parameter logic [AW-1:0]  PTR_B      = 16'h0104,
  parameter int             DESC_WORDS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [1:0]    hostWrSel,
  input  logic [DW-1:0] hostWrData,
  input  ctrlStrobe_t   strb,
  output dpStatus_t     stat,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  input  logic [DW-1:0] ramRdata,
  input  logic          xferErr,
  input  logic [DW-1:0] timeTag,
  output logic [DW-1:0] xferCtrl,
  output logic [AW-1:0] xferBlkAddr,
  output logic          irqEol,
  output logic          irqErr
);

  localparam logic [AW-1:0] TT_OFS   = AW'(1);
  localparam logic [AW-1:0] MBA_OFS  = AW'(DESC_WORDS - 1);
  localparam logic [AW-1:0] SP_STEP  = AW'(DESC_WORDS);
  localparam logic [AW-1:0] CNT_OFS  = AW'(1);

  logic          cfgArea, cfgStop, maskEol, maskErr;
  logic          areaCur;
  logic [AW-1:0] spReg, mbaReg;
  logic [DW-1:0] cntReg, cwReg, ttReg;
  logic          errReg;
  logic [AW-1:0] ptrAddr;
  logic [DW-1:0] bswWord;

  // host registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgArea <= 1'b0;
      cfgStop <= 1'b0;
      maskEol <= 1'b0;
      maskErr <= 1'b0;
    end else if (hostWrEn) begin
      case (hostSel_e'(hostWrSel))
        HS_CFG: begin
          cfgArea <= hostWrData[CFG_AREA_BIT];
          cfgStop <= hostWrData[CFG_STOP_BIT];
        end
        HS_MASK: begin
          maskEol <= hostWrData[MASK_EOL_BIT];
          maskErr <= hostWrData[MASK_ERR_BIT];
        end
        default: ;
      endcase
    end
  end

  // active area, only moved on control's latch strobe
  always_ff @(posedge clk) begin
    if (!rstN)               areaCur <= 1'b0;
    else if (strb.latchArea) areaCur <= cfgArea;
  end

  // message state captured from RAM and transfer port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg  <= '0;
      cntReg <= '0;
      mbaReg <= '0;
      cwReg  <= '0;
      ttReg  <= '0;
      errReg <= 1'b0;
    end else begin
      if (strb.capSp)  spReg  <= AW'(ramRdata);
      if (strb.capCnt) cntReg <= ramRdata;
      if (strb.capMba) mbaReg <= AW'(ramRdata);
      if (strb.capCw)  cwReg  <= ramRdata;
      if (strb.capDone) begin
        ttReg  <= timeTag;
        errReg <= xferErr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEol <= 1'b0;
      irqErr <= 1'b0;
    end else begin
      irqEol <= strb.raiseEol && maskEol;
      irqErr <= strb.raiseErr && maskErr;
    end
  end

  assign ptrAddr = areaCur ? PTR_B : PTR_A;

  always_comb begin
    bswWord               = '0;
    bswWord[BSW_DONE_BIT] = 1'b1;
    bswWord[BSW_ERR_BIT]  = errReg;
  end

  always_comb begin
    ramAddr  = ptrAddr;
    ramWdata = '0;
    case (strb.addrSel)
      AS_PTR: begin ramAddr = ptrAddr;           ramWdata = DW'(spReg + SP_STEP); end
      AS_CNT: begin ramAddr = ptrAddr + CNT_OFS; ramWdata = cntReg + DW'(1);      end
      AS_MBA: begin ramAddr = spReg + MBA_OFS;   ramWdata = '0;                   end
      AS_CW:  begin ramAddr = mbaReg;            ramWdata = '0;                   end
      AS_BSW: begin ramAddr = spReg;             ramWdata = bswWord;              end
      AS_TT:  begin ramAddr = spReg + TT_OFS;    ramWdata = ttReg;                end
      default: ;
    endcase
  end

  assign stat.startReq   = hostWrEn && (hostSel_e'(hostWrSel) == HS_START);
  assign stat.cntAllOnes = &cntReg;
  assign stat.lastErr    = errReg;
  assign stat.stopOnErr  = cfgStop;

  assign xferCtrl    = cwReg;
  assign xferBlkAddr = mbaReg + AW'(1);

  // R7
  area_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferReq |=> $stable(areaCur));

  // R9
  eol_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqEol |=> !irqEol);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |=> !irqErr);

  // R9
  eol_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqEol |-> $past(maskEol));

  // R9
  err_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |-> $past(maskErr));

endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
#(
  parameter int            DW         = 16,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] PTR_A      = 16'h0100,
  parameter logic [AW-1:0] PTR_B      = 16'h0104,
  parameter int            DESC_WORDS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [1:0]    hostWrSel,
  input  logic [DW-1:0] hostWrData,
  output logic          ramReq,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  input  logic          ramGnt,
  input  logic [DW-1:0] ramRdata,
  output logic          xferReq,
  output logic [DW-1:0] xferCtrl,
  output logic [AW-1:0] xferBlkAddr,
  input  logic          xferDone,
  input  logic          xferErr,
  input  logic [DW-1:0] timeTag,
  output logic          irqEol,
  output logic          irqErr
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  bcs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .ramGnt   (ramGnt),
    .xferDone (xferDone),
    .strb     (strb)
  );

  bcs_datapath #(
    .DW         (DW),
    .AW         (AW),
    .PTR_A      (PTR_A),
    .PTR_B      (PTR_B),
    .DESC_WORDS (DESC_WORDS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrEn    (hostWrEn),
    .hostWrSel   (hostWrSel),
    .hostWrData  (hostWrData),
    .strb        (strb),
    .stat        (stat),
    .ramAddr     (ramAddr),
    .ramWdata    (ramWdata),
    .ramRdata    (ramRdata),
    .xferErr     (xferErr),
    .timeTag     (timeTag),
    .xferCtrl    (xferCtrl),
    .xferBlkAddr (xferBlkAddr),
    .irqEol      (irqEol),
    .irqErr      (irqErr)
  );

  assign ramReq  = strb.ramReq;
  assign ramWe   = strb.ramWe;
  assign xferReq = strb.xferReq;

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramReq && !ramGnt |=> $stable(ramAddr) && $stable(ramWdata));

endmodule

// File: tb/bcs_seq_bench.sv
module bcs_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostWrSel = 2'd3;
  logic [15:0] hostWrData = '0;
  logic        ramReq, ramWe, ramGnt;
  logic [15:0] ramAddr, ramWdata;
  logic [15:0] ramRdata = '0;
  logic        xferReq;
  logic [15:0] xferCtrl, xferBlkAddr;
  logic        xferDone = 1'b0;
  logic        xferErr = 1'b0;
  logic [15:0] timeTag = 16'h1000;
  logic        irqEol, irqErr;

  always #2 clk = ~clk;

  bcs_seq u_bcs_seq (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrData(hostWrData), .ramReq(ramReq), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramGnt(ramGnt), .ramRdata(ramRdata), .xferReq(xferReq),
    .xferCtrl(xferCtrl), .xferBlkAddr(xferBlkAddr), .xferDone(xferDone),
    .xferErr(xferErr), .timeTag(timeTag), .irqEol(irqEol), .irqErr(irqErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mem [0:1023];
  logic        gntOn = 1'b1;
  logic        stallMode = 1'b0;
  logic [7:0]  errPlan = '0;
  int          xferSeen = 0;
  int          eolCnt = 0;
  int          errCnt = 0;
  int          latCnt = 0;
  int          gntCnt = 0;
  logic [15:0] seenCtrl [0:15];
  logic [15:0] seenBlk  [0:15];
  logic [15:0] expTT    [0:15];
  logic        gotFirst = 1'b0;
  logic [15:0] firstAddr = '0;

  localparam int XFER_LAT = 4;

  assign ramGnt = ramReq && gntOn;

  typedef struct packed {
    logic [3:0] nMsg;
    logic       area;
    logic       stop;
    logic [7:0] errAt;
    logic [1:0] irqMask;
    logic       stall;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2, 1'b0, 1'b0, 8'h00, 2'b11, 1'b0},
    '{4'd3, 1'b1, 1'b0, 8'h02, 2'b11, 1'b1},
    '{4'd4, 1'b0, 1'b1, 8'h04, 2'b11, 1'b0},
    '{4'd0, 1'b1, 1'b0, 8'h00, 2'b01, 1'b0},
    '{4'd2, 1'b0, 1'b0, 8'h03, 2'b00, 1'b1},
    '{4'd3, 1'b1, 1'b1, 8'h04, 2'b10, 1'b1}
  };

  // RAM model: writes land and read data appears on the edge after the grant
  initial begin
    forever begin
      @(posedge clk);
      if (ramReq && ramGnt) begin
        if (!gotFirst) begin
          gotFirst  = 1'b1;
          firstAddr = ramAddr;
        end
        if (ramWe) mem[ramAddr[9:0]] <= ramWdata;
        else       ramRdata <= mem[ramAddr[9:0]];
      end
    end
  end

  // transfer port, grant pattern, time tag and interrupt counting
  initial begin
    forever begin
      @(negedge clk);
      timeTag = timeTag + 16'd7;
      gntCnt++;
      gntOn = stallMode ? gntCnt[0] : 1'b1;
      if (irqEol) eolCnt++;
      if (irqErr) errCnt++;
      if (xferDone) begin
        xferDone = 1'b0;
        xferErr  = 1'b0;
      end else if (xferReq) begin
        latCnt++;
        if (latCnt == XFER_LAT) begin
          xferDone = 1'b1;
          xferErr  = errPlan[xferSeen[2:0]];
          seenCtrl[xferSeen] = xferCtrl;
          seenBlk[xferSeen]  = xferBlkAddr;
          expTT[xferSeen]    = timeTag;
          xferSeen++;
          latCnt = 0;
        end
      end else begin
        latCnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrSel  = sel;
    hostWrData = data;
    @(negedge clk);
    hostWrEn   = 1'b0;
    hostWrSel  = 2'd3;
  endtask

  function automatic logic [15:0] stackBase(input logic area);
    return area ? 16'h0300 : 16'h0200;
  endfunction

  function automatic logic [15:0] mbaOf(input logic area, input int i);
    return 16'h0280 + (area ? 16'h0100 : 16'h0000) + 16'(8 * i);
  endfunction

  function automatic logic [15:0] cwOf(input logic area, input int i);
    return 16'hC000 | (area ? 16'h0100 : 16'h0000) | 16'(i);
  endfunction

  task automatic setupArea(input logic area, input int n);
    logic [15:0] ptr;
    logic [15:0] base;
    ptr  = area ? 16'h0104 : 16'h0100;
    base = stackBase(area);
    mem[ptr[9:0]]       = base;
    mem[ptr[9:0] + 1]   = 16'hFFFF - 16'(n);
    for (int i = 0; i < 8; i++) begin
      mem[base[9:0] + 10'(4*i)]     = 16'h0000;
      mem[base[9:0] + 10'(4*i + 1)] = 16'h0000;
      mem[base[9:0] + 10'(4*i + 2)] = 16'h5A00 | 16'(i);
      mem[base[9:0] + 10'(4*i + 3)] = mbaOf(area, i);
      mem[mbaOf(area, i) & 16'h03FF] = cwOf(area, i);
    end
  endtask

  task automatic resetCounters();
    xferSeen = 0;
    eolCnt   = 0;
    errCnt   = 0;
    gotFirst = 1'b0;
  endtask

  task automatic waitQuiet();
    int quiet = 0;
    int guard = 0;
    while (quiet < 20 && guard < 20000) begin
      @(negedge clk);
      if (ramReq || xferReq) quiet = 0;
      else quiet++;
      guard++;
    end
    check(quiet >= 20, "R11 walk finished", 16'(guard), 16'(20000));
  endtask

  task automatic runVector(input vec_t v);
    int k = int'(v.nMsg);
    bit halted = 0;
    int errs = 0;
    logic [15:0] base;
    logic [15:0] ptr;
    for (int i = 0; i < int'(v.nMsg); i++) begin
      if (v.stop && v.errAt[i]) begin
        k = i + 1;
        halted = 1;
        break;
      end
    end
    for (int i = 0; i < k; i++) if (v.errAt[i]) errs++;
    base = stackBase(v.area);
    ptr  = v.area ? 16'h0104 : 16'h0100;
    setupArea(v.area, int'(v.nMsg));
    errPlan   = v.errAt;
    stallMode = v.stall;
    resetCounters();
    hostWrite(2'd1, {14'b0, v.irqMask});
    hostWrite(2'd0, {1'b0, v.stop, v.area, 13'b0});
    hostWrite(2'd2, 16'h0000);
    waitQuiet();
    // R2 first access is the selected pointer
    check(firstAddr == ptr, "R2 first address", firstAddr, ptr);
    for (int i = 0; i < k; i++) begin
      logic [15:0] d;
      d = base + 16'(4*i);
      // R5 status word and time tag
      check(mem[d[9:0]] == (16'h8000 | 16'(v.errAt[i])), "R5 status word",
            mem[d[9:0]], 16'h8000 | 16'(v.errAt[i]));
      check(mem[d[9:0] + 1] == expTT[i], "R5 time tag", mem[d[9:0] + 1], expTT[i]);
      // R3 spare word untouched
      check(mem[d[9:0] + 2] == (16'h5A00 | 16'(i)), "R3 spare word",
            mem[d[9:0] + 2], 16'h5A00 | 16'(i));
      // R4 control word and data address
      check(seenCtrl[i] == cwOf(v.area, i), "R4 control word", seenCtrl[i], cwOf(v.area, i));
      check(seenBlk[i] == mbaOf(v.area, i) + 16'd1, "R4 data address",
            seenBlk[i], mbaOf(v.area, i) + 16'd1);
    end
    if (k < int'(v.nMsg)) begin
      logic [15:0] d;
      d = base + 16'(4*k);
      // R8 descriptor after the halt untouched
      check(mem[d[9:0]] == 16'h0000, "R8 next descriptor untouched", mem[d[9:0]], 16'h0000);
    end
    // R6 pointer and count
    check(mem[ptr[9:0]] == base + 16'(4*k), "R6 pointer", mem[ptr[9:0]], base + 16'(4*k));
    check(mem[ptr[9:0] + 1] == 16'hFFFF - 16'(v.nMsg) + 16'(k), "R6 count",
          mem[ptr[9:0] + 1], 16'hFFFF - 16'(v.nMsg) + 16'(k));
    if (v.stall)
      check(xferSeen == k, "R10 messages under stalled grants", 16'(xferSeen), 16'(k));
    else
      check(xferSeen == k, "R8 message count", 16'(xferSeen), 16'(k));
    // R9 interrupt pulses
    check(eolCnt == ((v.irqMask[0] && !halted) ? 1 : 0), "R9 end-of-list pulses",
          16'(eolCnt), (v.irqMask[0] && !halted) ? 16'd1 : 16'd0);
    check(errCnt == (v.irqMask[1] ? errs : 0), "R9 error pulses",
          16'(errCnt), v.irqMask[1] ? 16'(errs) : 16'd0);
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ramReq == 1'b0, "R1 no RAM request", 16'(ramReq), 16'd0);
    check(xferReq == 1'b0, "R1 no transfer request", 16'(xferReq), 16'd0);
    check(!irqEol && !irqErr, "R1 no interrupt", {14'b0, irqEol, irqErr}, 16'd0);
    repeat (10) @(negedge clk);
    check(ramReq == 1'b0, "R1 idle without start", 16'(ramReq), 16'd0);

    for (int v = 0; v < NVEC; v++) runVector(VECS[v]);

    // R7 area change mid-message; R11 start while running
    setupArea(1'b0, 3);
    setupArea(1'b1, 1);
    errPlan   = '0;
    stallMode = 1'b0;
    resetCounters();
    hostWrite(2'd1, 16'h0003);
    hostWrite(2'd0, 16'h0000);
    hostWrite(2'd2, 16'h0000);
    while (!xferReq) @(negedge clk);
    hostWrite(2'd0, 16'h2000);
    hostWrite(2'd2, 16'h0000);
    waitQuiet();
    check(mem[10'h200] == 16'h8000, "R7 first message in area A", mem[10'h200], 16'h8000);
    check(mem[10'h100] == 16'h0204, "R7 area A pointer", mem[10'h100], 16'h0204);
    check(mem[10'h101] == 16'hFFFD, "R7 area A count", mem[10'h101], 16'hFFFD);
    check(mem[10'h204] == 16'h0000, "R7 area A second descriptor untouched", mem[10'h204], 16'h0000);
    check(mem[10'h300] == 16'h8000, "R7 area B descriptor written", mem[10'h300], 16'h8000);
    check(mem[10'h104] == 16'h0304, "R7 area B pointer", mem[10'h104], 16'h0304);
    check(mem[10'h105] == 16'hFFFF, "R7 area B count", mem[10'h105], 16'hFFFF);
    check(seenCtrl[1] == cwOf(1'b1, 0), "R7 second control word from B", seenCtrl[1], cwOf(1'b1, 0));
    check(xferSeen == 2, "R11 start while running ignored", 16'(xferSeen), 16'd2);
    check(eolCnt == 1, "R9 single end-of-list", 16'(eolCnt), 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule